// File: doc/BRIEF.md
# Coprocessor Exception Status Controller

This block is the system-control coprocessor state of a small 32-bit processor core. It owns the Status register, the Cause register and the exception return address (EPC). Software writes to these registers arrive through a select-plus-data port. A return-from-exception strobe pops the processor's mode and interrupt-enable stack. Exceptions requested by the pipeline, such as a breakpoint or a system call, push that stack and record the exception code, the branch-delay flag and the return address.

Status bits [5:0] form a three-deep stack of two-bit pairs. Bit 0 of each pair is the interrupt enable and bit 1 is the mode. Entering an exception shifts the stack up by one pair and clears the current pair, so the core enters kernel mode with interrupts off. Returning from an exception shifts the stack back down.

Two software-interrupt request bits in Cause, bits [9:8], are writable by software. When a request bit, its mask bit in Status and the global enable Status bit 0 are all set, the block takes an interrupt exception by itself. The pipeline supplies the current instruction address and delay-slot flag on every cycle, so that an interrupt taken at any instruction boundary can record where to resume.

Top module: `csc_top`

## Requirements
- R1: While reset is asserted, and immediately after it is released, Status, Cause and EPC read zero and `exc_taken_o` is low.
- R2: A register write with select 0 loads the full 32-bit Status word. A write with select 2 or 3 changes no register.
- R3: A register write with select 1 changes only Cause bits [9:8], which take data bits [9:8]. Every other Cause bit keeps its value.
- R4: A return-from-exception sets Status bits [3:0] to the old Status bits [5:2] and leaves Status bits [31:4] unchanged.
- R5: A software interrupt is pending when (Cause & Status) bits [9:8] are nonzero and Status bit 0 is 1. In any cycle where one is pending, `exc_taken_o` is high with code 0, and the exception is taken on that clock edge.
- R6: On exception entry, Status bits [5:0] become old bits [3:0] followed by two zero bits. Status bits [31:6] do not change.
- R7: On exception entry, Cause bits [6:2] take the exception code, or 0 for a software interrupt, and Cause bit 31 takes the delay-slot flag. All other Cause bits are kept.
- R8: On exception entry, EPC takes the supplied instruction address, or that address minus 4 when the delay-slot flag is set.
- R9: A requested exception with code 9 (breakpoint) leaves Cause bits [7:0] equal to 0x24, provided those bits were zero outside the code field.
- R10: An exception request takes priority over a pending software interrupt. Any exception entry discards a register write or a return-from-exception in the same cycle. A return-from-exception takes priority over a Status write in the same cycle.
- R11: `exc_boot_vec_o` follows Status bit 22 and selects the boot vector set for the exception being taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_wr_sel_i | input | 2 | Register select: 0 Status, 1 Cause, others none |
| reg_wr_data_i | input | 32 | Register write data |
| rfe_i | input | 1 | Return-from-exception strobe |
| exc_req_i | input | 1 | Exception request from the pipeline |
| exc_code_i | input | 5 | Code of the requested exception |
| instr_pc_i | input | 32 | Address of the current or faulting instruction |
| instr_in_delay_i | input | 1 | The current instruction sits in a branch-delay slot |
| exc_taken_o | output | 1 | An exception is taken on this clock edge |
| exc_code_o | output | 5 | Code of the exception being taken |
| exc_boot_vec_o | output | 1 | Vector select: boot vector set |
| status_o | output | 32 | Status register |
| cause_o | output | 32 | Cause register |
| epc_o | output | 32 | Exception return address |

## Verification
The assertions check several properties on every cycle: the stack push on entry and the stack pop on return, the write mask on Cause, the code, delay-bit and EPC capture on entry, and the rule that a pending interrupt always raises `exc_taken_o` with code 0. The bench scenarios show what single cycles cannot. These include chains of interrupt, return and re-interrupt that depend on the previous Status contents, masking by the individual enable bits, the three-way collision of request, write and return in one cycle, and the change of the vector select after a Status write.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int DATA_W     = 32;
  localparam int SEL_W      = 2;
  localparam int CODE_W     = 5;
  localparam int CODE_LSB   = 2;
  localparam int BD_BIT     = 31;
  localparam int SWI_LSB    = 8;
  localparam int SWI_N      = 2;
  localparam int IE_BIT     = 0;
  localparam int BOOT_BIT   = 22;
  localparam int STK_LEVELS = 3;
  localparam int PAIR_W     = 2;
  localparam int STK_W      = STK_LEVELS * PAIR_W;

  localparam logic [DATA_W-1:0] SWI_MASK =
    DATA_W'(((1 << SWI_N) - 1) << SWI_LSB);
  localparam logic [CODE_W-1:0] CODE_INT = '0;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_NONE2  = 2'd2,
    SEL_NONE3  = 2'd3
  } reg_sel_e;

  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/csc_irq_detect.sv
module csc_irq_detect
  import csc_pkg::*;
(
  input  logic [SWI_N-1:0] req_bits_i,
  input  logic [SWI_N-1:0] mask_bits_i,
  input  logic             global_en_i,
  output logic             pending_o
);
  logic [SWI_N-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < SWI_N; g++) begin : g_hit
      assign hit[g] = req_bits_i[g] & mask_bits_i[g];
    end
  endgenerate

  assign pending_o = (|hit) & global_en_i;
endmodule

// File: rtl/csc_status_reg.sv
module csc_status_reg
  import csc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en_i,
  input  word_t wr_data_i,
  input  logic  rfe_i,
  input  logic  enter_i,
  output word_t status_o
);
  word_t st_q, st_d;
  logic  st_upd;

  always_comb begin
    st_d   = st_q;
    st_upd = 1'b0;
    if (enter_i) begin
      st_d[STK_W-1:0] = {st_q[STK_W-PAIR_W-1:0], {PAIR_W{1'b0}}};
      st_upd          = 1'b1;
    end else if (rfe_i) begin
      st_d[STK_W-PAIR_W-1:0] = st_q[STK_W-1:PAIR_W];
      st_upd                 = 1'b1;
    end else if (wr_en_i) begin
      st_d   = wr_data_i;
      st_upd = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= '0;
    else if (st_upd) st_q <= st_d;
  end

  assign status_o = st_q;

  // R6
  stack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_i |=> (st_q[STK_W-1:0] == {$past(st_q[STK_W-PAIR_W-1:0]), {PAIR_W{1'b0}}})
             && (st_q[DATA_W-1:STK_W] == $past(st_q[DATA_W-1:STK_W])));

  // R4
  stack_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe_i && !enter_i) |=> (st_q[STK_W-PAIR_W-1:0] == $past(st_q[STK_W-1:PAIR_W]))
                         && (st_q[DATA_W-1:STK_W-PAIR_W] == $past(st_q[DATA_W-1:STK_W-PAIR_W])));

  // R2
  status_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !rfe_i && !enter_i) |=> st_q == $past(wr_data_i));
endmodule

// File: rtl/csc_cause_reg.sv
module csc_cause_reg
  import csc_pkg::*;
#(
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  word_t             wr_data_i,
  input  logic              enter_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              delay_i,
  input  word_t             pc_i,
  output word_t             cause_o,
  output word_t             epc_o
);
  localparam word_t STEP = DATA_W'(INSTR_BYTES);

  word_t ca_q, ca_d, epc_q, epc_d;
  logic  ca_upd;

  always_comb begin
    ca_d   = ca_q;
    ca_upd = 1'b0;
    if (enter_i) begin
      ca_d[CODE_LSB+CODE_W-1:CODE_LSB] = code_i;
      ca_d[BD_BIT]                     = delay_i;
      ca_upd                           = 1'b1;
    end else if (wr_en_i) begin
      ca_d   = (ca_q & ~SWI_MASK) | (wr_data_i & SWI_MASK);
      ca_upd = 1'b1;
    end
  end

  always_comb begin
    epc_d = delay_i ? (pc_i - STEP) : pc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ca_q <= '0;
    else if (ca_upd) ca_q <= ca_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       epc_q <= '0;
    else if (enter_i) epc_q <= epc_d;
  end

  assign cause_o = ca_q;
  assign epc_o   = epc_q;

  // R3
  cause_wr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !enter_i) |=> ((ca_q & ~SWI_MASK) == ($past(ca_q) & ~SWI_MASK))
                           && ((ca_q & SWI_MASK) == ($past(wr_data_i) & SWI_MASK)));

  // R7
  cause_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_i |=> (ca_q[CODE_LSB+CODE_W-1:CODE_LSB] == $past(code_i))
             && (ca_q[BD_BIT] == $past(delay_i))
             && ((ca_q & SWI_MASK) == ($past(ca_q) & SWI_MASK)));

  // R8
  epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_i && delay_i) |=> epc_q + STEP == $past(pc_i));
endmodule

// File: rtl/csc_top.sv
module csc_top
  import csc_pkg::*;
#(
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en_i,
  input  logic [1:0]        reg_wr_sel_i,
  input  logic [31:0]       reg_wr_data_i,
  input  logic              rfe_i,
  input  logic              exc_req_i,
  input  logic [4:0]        exc_code_i,
  input  logic [31:0]       instr_pc_i,
  input  logic              instr_in_delay_i,
  output logic              exc_taken_o,
  output logic [4:0]        exc_code_o,
  output logic              exc_boot_vec_o,
  output logic [31:0]       status_o,
  output logic [31:0]       cause_o,
  output logic [31:0]       epc_o
);
  word_t status_w, cause_w, epc_w;
  logic  irq_pending, enter, status_wr, cause_wr, rfe_eff;
  logic [CODE_W-1:0] take_code;

  csc_irq_detect u_irq (
    .req_bits_i  (cause_w[SWI_LSB+SWI_N-1:SWI_LSB]),
    .mask_bits_i (status_w[SWI_LSB+SWI_N-1:SWI_LSB]),
    .global_en_i (status_w[IE_BIT]),
    .pending_o   (irq_pending)
  );

  always_comb begin
    enter     = exc_req_i | irq_pending;
    take_code = exc_req_i ? exc_code_i : CODE_INT;
    rfe_eff   = rfe_i & ~enter;
    status_wr = reg_wr_en_i & (reg_sel_e'(reg_wr_sel_i) == SEL_STATUS) & ~enter;
    cause_wr  = reg_wr_en_i & (reg_sel_e'(reg_wr_sel_i) == SEL_CAUSE) & ~enter;
  end

  csc_status_reg u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (status_wr),
    .wr_data_i (reg_wr_data_i),
    .rfe_i     (rfe_eff),
    .enter_i   (enter),
    .status_o  (status_w)
  );

  csc_cause_reg #(.INSTR_BYTES(INSTR_BYTES)) u_cause (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (cause_wr),
    .wr_data_i (reg_wr_data_i),
    .enter_i   (enter),
    .code_i    (take_code),
    .delay_i   (instr_in_delay_i),
    .pc_i      (instr_pc_i),
    .cause_o   (cause_w),
    .epc_o     (epc_w)
  );

  assign exc_taken_o    = enter;
  assign exc_code_o     = take_code;
  assign exc_boot_vec_o = status_w[BOOT_BIT];
  assign status_o       = status_w;
  assign cause_o        = cause_w;
  assign epc_o          = epc_w;

  // R5
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(cause_o[SWI_LSB+SWI_N-1:SWI_LSB] & status_o[SWI_LSB+SWI_N-1:SWI_LSB]))
      && status_o[IE_BIT] && !exc_req_i) |-> (exc_taken_o && exc_code_o == CODE_INT));

  // R5
  irq_self_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken_o |=> !status_o[IE_BIT]);

  // R10
  req_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_i |-> (exc_taken_o && exc_code_o == exc_code_i));

  // R10
  write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_taken_o && reg_wr_en_i && reg_wr_sel_i == 2'd1) |=>
      cause_o[SWI_LSB+SWI_N-1:SWI_LSB] == $past(cause_o[SWI_LSB+SWI_N-1:SWI_LSB]));
endmodule

// File: tb/tb_csc_top.sv
module tb_csc_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en_i;
  logic [1:0]  reg_wr_sel_i;
  logic [31:0] reg_wr_data_i;
  logic        rfe_i;
  logic        exc_req_i;
  logic [4:0]  exc_code_i;
  logic [31:0] instr_pc_i;
  logic        instr_in_delay_i;
  logic        exc_taken_o;
  logic [4:0]  exc_code_o;
  logic        exc_boot_vec_o;
  logic [31:0] status_o, cause_o, epc_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  csc_top dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en_i(reg_wr_en_i), .reg_wr_sel_i(reg_wr_sel_i), .reg_wr_data_i(reg_wr_data_i),
    .rfe_i(rfe_i), .exc_req_i(exc_req_i), .exc_code_i(exc_code_i),
    .instr_pc_i(instr_pc_i), .instr_in_delay_i(instr_in_delay_i),
    .exc_taken_o(exc_taken_o), .exc_code_o(exc_code_o), .exc_boot_vec_o(exc_boot_vec_o),
    .status_o(status_o), .cause_o(cause_o), .epc_o(epc_o)
  );

  // op: 0 idle, 1 write Status, 2 write Cause, 3 exception request, 4 return
  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] data;
    logic [4:0]  code;
    logic        dly;
    logic [31:0] pc;
    logic [31:0] es;
    logic [31:0] ec;
    logic [31:0] ee;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 32'h0000_0301, 5'd0, 1'b0, 32'h0,      32'h0000_0301, 32'h0000_0000, 32'h0},
    '{3'd2, 32'hFFFF_FFFF, 5'd0, 1'b0, 32'h0,      32'h0000_0301, 32'h0000_0300, 32'h0},
    '{3'd0, 32'h0,         5'd0, 1'b0, 32'h1000,   32'h0000_0304, 32'h0000_0300, 32'h1000},
    '{3'd4, 32'h0,         5'd0, 1'b0, 32'h1004,   32'h0000_0301, 32'h0000_0300, 32'h1000},
    '{3'd0, 32'h0,         5'd0, 1'b1, 32'h2004,   32'h0000_0304, 32'h8000_0300, 32'h2000},
    '{3'd2, 32'h0,         5'd0, 1'b0, 32'h0,      32'h0000_0304, 32'h8000_0000, 32'h2000},
    '{3'd4, 32'h0,         5'd0, 1'b0, 32'h0,      32'h0000_0301, 32'h8000_0000, 32'h2000},
    '{3'd3, 32'h0,         5'd9, 1'b0, 32'h3000,   32'h0000_0304, 32'h0000_0024, 32'h3000},
    '{3'd3, 32'h0,         5'd8, 1'b1, 32'h4008,   32'h0000_0310, 32'h8000_0020, 32'h4004},
    '{3'd1, 32'h0000_003C, 5'd0, 1'b0, 32'h0,      32'h0000_003C, 32'h8000_0020, 32'h4004},
    '{3'd4, 32'h0,         5'd0, 1'b0, 32'h0,      32'h0000_003F, 32'h8000_0020, 32'h4004},
    '{3'd2, 32'h0000_0100, 5'd0, 1'b0, 32'h0,      32'h0000_003F, 32'h8000_0120, 32'h4004},
    '{3'd0, 32'h0,         5'd0, 1'b0, 32'h0,      32'h0000_003F, 32'h8000_0120, 32'h4004},
    '{3'd1, 32'h0000_0100, 5'd0, 1'b0, 32'h0,      32'h0000_0100, 32'h8000_0120, 32'h4004},
    '{3'd1, 32'h0000_0101, 5'd0, 1'b0, 32'h0,      32'h0000_0101, 32'h8000_0120, 32'h4004},
    '{3'd0, 32'h0,         5'd0, 1'b0, 32'h5000,   32'h0000_0104, 32'h0000_0100, 32'h5000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    reg_wr_en_i = 0; reg_wr_sel_i = 0; reg_wr_data_i = 0; rfe_i = 0;
    exc_req_i = 0; exc_code_i = 0; instr_pc_i = 0; instr_in_delay_i = 0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", status_o, 32'h0);
    chk("R1 cause", cause_o, 32'h0);
    chk("R1 epc", epc_o, 32'h0);
    chk("R1 taken", {31'h0, exc_taken_o}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status after release", status_o, 32'h0);

    // vector walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      idle_in();
      case (VEC[i].op)
        3'd1: begin reg_wr_en_i = 1; reg_wr_sel_i = 2'd0; reg_wr_data_i = VEC[i].data; end
        3'd2: begin reg_wr_en_i = 1; reg_wr_sel_i = 2'd1; reg_wr_data_i = VEC[i].data; end
        3'd3: begin exc_req_i = 1; exc_code_i = VEC[i].code; end
        3'd4: rfe_i = 1;
        default: ;
      endcase
      instr_pc_i = VEC[i].pc;
      instr_in_delay_i = VEC[i].dly;
      @(negedge clk);
      chk($sformatf("R2/R4/R6 status row %0d", i), status_o, VEC[i].es);
      chk($sformatf("R3/R7/R9 cause row %0d", i), cause_o, VEC[i].ec);
      chk($sformatf("R8 epc row %0d", i), epc_o, VEC[i].ee);
    end
    idle_in();

    // R10: request collides with Cause write and return
    exc_req_i = 1; exc_code_i = 5'd4; instr_pc_i = 32'h6000;
    reg_wr_en_i = 1; reg_wr_sel_i = 2'd1; reg_wr_data_i = 32'h0; rfe_i = 1;
    #1;
    chk("R10 taken", {31'h0, exc_taken_o}, 32'h1);
    chk("R10 code", {27'h0, exc_code_o}, 32'h4);
    @(negedge clk);
    chk("R10 status", status_o, 32'h0000_0110);
    chk("R10 cause write dropped", cause_o, 32'h0000_0110);
    chk("R8 epc", epc_o, 32'h6000);

    // R2: unused select writes nothing
    idle_in();
    reg_wr_en_i = 1; reg_wr_sel_i = 2'd2; reg_wr_data_i = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R2 sel2 status", status_o, 32'h0000_0110);
    chk("R2 sel2 cause", cause_o, 32'h0000_0110);

    // R11: boot vector select follows Status bit 22
    idle_in();
    reg_wr_en_i = 1; reg_wr_sel_i = 2'd0; reg_wr_data_i = 32'h0040_0101;
    @(negedge clk);
    chk("R11 boot vec", {31'h0, exc_boot_vec_o}, 32'h1);
    // R10: request beats pending interrupt; R9 breakpoint in delay slot
    idle_in();
    exc_req_i = 1; exc_code_i = 5'd9; instr_pc_i = 32'h7000; instr_in_delay_i = 1;
    #1;
    chk("R10 request over irq code", {27'h0, exc_code_o}, 32'h9);
    @(negedge clk);
    chk("R6 status", status_o, 32'h0040_0104);
    chk("R9 cause", cause_o, 32'h8000_0124);
    chk("R8 epc delay", epc_o, 32'h0000_6FFC);

    // R10: return beats Status write; then R5 interrupt fires
    idle_in();
    rfe_i = 1; reg_wr_en_i = 1; reg_wr_sel_i = 2'd0; reg_wr_data_i = 32'h0;
    @(negedge clk);
    chk("R10 rfe over write", status_o, 32'h0040_0101);
    idle_in();
    instr_pc_i = 32'h8000;
    #1;
    chk("R5 pending taken", {31'h0, exc_taken_o}, 32'h1);
    chk("R5 pending code", {27'h0, exc_code_o}, 32'h0);
    @(negedge clk);
    chk("R5 status", status_o, 32'h0040_0104);
    chk("R7 cause", cause_o, 32'h0000_0100);
    chk("R8 epc", epc_o, 32'h8000);
    chk("R5 no retake", {31'h0, exc_taken_o}, 32'h0);

    // R1: asynchronous reset mid-run
    idle_in();
    #2;
    rst_n = 0;
    #1;
    chk("R1 async status", status_o, 32'h0);
    chk("R1 async cause", cause_o, 32'h0);
    chk("R1 async epc", epc_o, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule